// File: doc/BRIEF.md
# Doubleword Memory Access Watchpoint

This block is a debug watchpoint that sits beside a processor's memory access path. Software programs one physical doubleword address through two coprocessor-style registers. One is a low word that holds the lower address bits and two access-type enables. The other is a high word that supplies the upper address bits. On every cycle the block compares the physical address of the current load or store against the programmed doubleword. When the address matches and the enable for that access type is set, it raises a one-cycle exception request.

The three lowest bits of an access address take no part in the compare, so any byte inside the watched doubleword triggers the watchpoint. The two lowest bits of the low register act as a read-match enable (bit 0) and a write-match enable (bit 1). Bit 2 of the low register is not stored. When the high register holds zero, the watch range is the low 4 MB of physical space, which is address bits [21:3].

Exception vectoring, the pipeline that consumes the request, and address translation all lie outside this block. The reset input is expected to be asserted asynchronously and released synchronously by the surrounding clock domain.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset both watch registers read as zero and `watch_exc` is low.
- R2: A register write with index 18 stores write-data bits [21:3] as the watch address, bit 0 as the read enable and bit 1 as the write enable. Reading index 18 returns those bits in place, with bit 2 and bits [31:22] reading as zero.
- R3: A register write with index 19 stores write-data bits [9:0] as watch-address bits [31:22]. Reading index 19 returns them in bits [9:0], with all other bits reading as zero.
- R4: A register write to any index other than 18 or 19 changes neither watch register, and reading such an index returns zero.
- R5: A valid read (`acc_is_write`=0) whose address bits [31:3] equal the programmed address, while the read enable is set, drives `watch_exc` high in the cycle after the access strobe.
- R6: A valid write (`acc_is_write`=1) whose address bits [31:3] equal the programmed address, while the write enable is set, drives `watch_exc` high in the cycle after the access strobe.
- R7: A matching access whose type has its enable clear produces no request.
- R8: All eight byte offsets (address bits [2:0] = 0 to 7) inside the watched doubleword match.
- R9: An access to the doubleword directly below or directly above the watched one produces no request.
- R10: With both enable bits clear, no access ever produces a request.
- R11: `watch_exc` is high only in a cycle that directly follows a matching valid access strobe, and it is low in every other cycle.
- R12: The high register takes part in the compare. An access that matches bits [21:3] but differs in bits [31:22] produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 5 | Coprocessor register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_idx` |
| acc_valid | input | 1 | Memory access strobe |
| acc_addr | input | 32 | Physical address of the access |
| acc_is_write | input | 1 | 1 for a store, 0 for a load |
| watch_exc | output | 1 | One-cycle watch exception request |

## Verification
The bench sweeps all eight byte offsets of the watched doubleword. A design that compared bit 2 or any lower bit would miss some of them. It probes the doublewords on either side of the target, where an off-by-one mask would report a false hit. It also moves the upper address bits away from the high register value, where a design that ignored the high register would fire. Accesses of the disabled type, and accesses made with both enables clear, must stay silent; a design that ignored or swapped an enable would fire on them. Readback with bit 2 and the high-order bits set in the written data catches a design that stores bits it should drop. Back-to-back hit and miss cycles expose a request that is stretched or late.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WP_ADDR_W = 32;
  localparam int WP_SPLIT  = 22;
  localparam int WP_DW_LSB = 3;
  localparam int WP_IDX_W  = 5;
  localparam int WP_LO_IDX = 18;
  localparam int WP_HI_IDX = 19;

  typedef struct packed {
    logic wr;
    logic rd;
  } wp_en_t;
endpackage

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
#(
  parameter int ADDR_W = WP_ADDR_W,
  parameter int SPLIT  = WP_SPLIT,
  parameter int DW_LSB = WP_DW_LSB,
  parameter int IDX_W  = WP_IDX_W,
  parameter int LO_IDX = WP_LO_IDX,
  parameter int HI_IDX = WP_HI_IDX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         idx,
  input  logic [ADDR_W-1:0]        wdata,
  output logic [ADDR_W-1:0]        rdata,
  output logic [SPLIT-1:DW_LSB]    lo_addr,
  output logic [ADDR_W-1:SPLIT]    hi_addr,
  output wp_en_t                   en
);
  localparam int HI_W = ADDR_W - SPLIT;
  localparam int PAD_LO = ADDR_W - SPLIT;
  localparam int PAD_HI = ADDR_W - HI_W;

  logic                  sel_lo, sel_hi;
  logic                  load_lo, load_hi;
  logic [SPLIT-1:DW_LSB] lo_addr_nxt;
  logic [HI_W-1:0]       hi_nxt;
  logic [HI_W-1:0]       hi_q;
  wp_en_t                en_nxt;

  // next-state
  always_comb begin
    sel_lo      = (idx == IDX_W'(LO_IDX));
    sel_hi      = (idx == IDX_W'(HI_IDX));
    load_lo     = wr_en && sel_lo;
    load_hi     = wr_en && sel_hi;
    lo_addr_nxt = wdata[SPLIT-1:DW_LSB];
    en_nxt.rd   = wdata[0];
    en_nxt.wr   = wdata[1];
    hi_nxt      = wdata[HI_W-1:0];
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_addr <= '0;
      en      <= '0;
    end else if (load_lo) begin
      lo_addr <= lo_addr_nxt;
      en      <= en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (load_hi) begin
      hi_q <= hi_nxt;
    end
  end

  assign hi_addr = hi_q;

  // readback: bit 2 of the low word is never stored
  always_comb begin
    rdata = '0;
    if (sel_lo) begin
      rdata = {{PAD_LO{1'b0}}, lo_addr, 1'b0, en.wr, en.rd};
    end else if (sel_hi) begin
      rdata = {{PAD_HI{1'b0}}, hi_q};
    end
  end
endmodule

// File: rtl/wp_match.sv
module wp_match
  import wp_pkg::*;
#(
  parameter int ADDR_W = WP_ADDR_W,
  parameter int SPLIT  = WP_SPLIT,
  parameter int DW_LSB = WP_DW_LSB
) (
  input  logic                  acc_valid,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic                  acc_is_write,
  input  logic [SPLIT-1:DW_LSB] lo_addr,
  input  logic [ADDR_W-1:SPLIT] hi_addr,
  input  wp_en_t                en,
  output logic                  hit
);
  logic addr_eq;
  logic type_ok;

  always_comb begin
    addr_eq = (acc_addr[SPLIT-1:DW_LSB] == lo_addr) &&
              (acc_addr[ADDR_W-1:SPLIT] == hi_addr);
    type_ok = acc_is_write ? en.wr : en.rd;
    hit     = acc_valid && addr_eq && type_ok;
  end
endmodule

// File: rtl/wp_pulse.sv
module wp_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic exc
);
  logic exc_nxt;

  always_comb exc_nxt = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc <= 1'b0;
    else        exc <= exc_nxt;
  end
endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W = WP_ADDR_W,
  parameter int SPLIT  = WP_SPLIT,
  parameter int DW_LSB = WP_DW_LSB,
  parameter int IDX_W  = WP_IDX_W,
  parameter int LO_IDX = WP_LO_IDX,
  parameter int HI_IDX = WP_HI_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_is_write,
  output logic              watch_exc
);
  logic [SPLIT-1:DW_LSB] lo_addr;
  logic [ADDR_W-1:SPLIT] hi_addr;
  wp_en_t                en;
  logic                  en_r, en_w;
  logic                  hit;

  assign en_r = en.rd;
  assign en_w = en.wr;

  wp_regs #(
    .ADDR_W(ADDR_W), .SPLIT(SPLIT), .DW_LSB(DW_LSB),
    .IDX_W(IDX_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .idx(reg_idx),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .en(en)
  );

  wp_match #(
    .ADDR_W(ADDR_W), .SPLIT(SPLIT), .DW_LSB(DW_LSB)
  ) u_match (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_write(acc_is_write),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .en(en), .hit(hit)
  );

  wp_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .hit(hit), .exc(watch_exc)
  );
endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk #(
  parameter int IDX_W  = 5,
  parameter int LO_IDX = 18,
  parameter int HI_IDX = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [IDX_W-1:0] reg_idx,
  input logic [1:0]       wdata_en,
  input logic             acc_valid,
  input logic             acc_is_write,
  input logic             en_r,
  input logic             en_w,
  input logic             watch_exc
);
  // R2
  lo_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_idx == IDX_W'(LO_IDX)) |=>
      (en_r == $past(wdata_en[0]) && en_w == $past(wdata_en[1])));

  // R4
  other_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_idx != IDX_W'(LO_IDX) && reg_idx != IDX_W'(HI_IDX)) |=>
      ($stable(en_r) && $stable(en_w)));

  // R10
  no_enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_r && !en_w) |=> !watch_exc);

  // R7
  read_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_is_write && !en_r) |=> !watch_exc);

  // R7
  write_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_is_write && !en_w) |=> !watch_exc);

  // R11
  exc_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    watch_exc |-> $past(acc_valid));
endmodule

bind mem_watch_unit wp_watch_chk #(
  .IDX_W(IDX_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
) u_wp_watch_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
  .wdata_en(reg_wdata[1:0]), .acc_valid(acc_valid),
  .acc_is_write(acc_is_write), .en_r(en_r), .en_w(en_w),
  .watch_exc(watch_exc)
);

// File: tb/tb_mem_watch_unit.sv
`timescale 1ns/1ps
module tb_mem_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_is_write = 1'b0;
  logic        watch_exc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb[$];

  // bench model of programmed state
  logic [18:0] m_lo = '0;
  logic [9:0]  m_hi = '0;
  bit          m_rd = 0, m_wr = 0;

  always #2.5 clk = ~clk;

  mem_watch_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_is_write(acc_is_write), .watch_exc(watch_exc)
  );

  // monitor: one expected item per driven cycle
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (watch_exc !== e.exp) begin
        errors++;
        $display("FAIL %s watch_exc actual %0b expected %0b", e.tag, watch_exc, e.exp);
      end
    end
  end

  function automatic bit model_hit(logic [31:0] a, bit wr);
    return (a[31:22] == m_hi) && (a[21:3] == m_lo) && (wr ? m_wr : m_rd);
  endfunction

  task automatic idle(string tag);
    @(negedge clk);
    reg_wr_en = 0; acc_valid = 0;
    sb.push_back('{0, tag});
  endtask

  task automatic wr_reg(logic [4:0] idx, logic [31:0] d);
    @(negedge clk);
    acc_valid = 0; reg_wr_en = 1; reg_idx = idx; reg_wdata = d;
    if (idx == 5'd18) begin m_lo = d[21:3]; m_rd = d[0]; m_wr = d[1]; end
    else if (idx == 5'd19) m_hi = d[9:0];
    sb.push_back('{0, "R4"});
    @(negedge clk);
    reg_wr_en = 0;
    sb.push_back('{0, "R4"});
  endtask

  task automatic access(logic [31:0] a, bit wr, string tag);
    @(negedge clk);
    reg_wr_en = 0; acc_valid = 1; acc_addr = a; acc_is_write = wr;
    sb.push_back('{model_hit(a, wr), tag});
  endtask

  task automatic rd_chk(logic [4:0] idx, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_wr_en = 0; acc_valid = 0; reg_idx = idx;
    sb.push_back('{0, tag});
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata idx %0d actual %08h expected %08h", tag, idx, reg_rdata, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    checks++;
    if (watch_exc !== 1'b0) begin
      errors++;
      $display("FAIL R1 watch_exc actual %0b expected 0", watch_exc);
    end
    rd_chk(5'd18, 32'h0, "R1");
    rd_chk(5'd19, 32'h0, "R1");

    // R2 low word: bit 2 and bits above 21 dropped, read enable only
    wr_reg(5'd18, 32'h8012345D);
    rd_chk(5'd18, 32'h00123459, "R2");
    // R3 high word
    wr_reg(5'd19, 32'hFFFFFC05);
    rd_chk(5'd19, 32'h00000005, "R3");
    // R4 foreign index
    wr_reg(5'd17, 32'hFFFFFFFF);
    rd_chk(5'd18, 32'h00123459, "R4");
    rd_chk(5'd19, 32'h00000005, "R4");
    rd_chk(5'd17, 32'h0, "R4");

    // watched doubleword now 0x01523458
    access(32'h01523458, 0, "R5");
    access(32'h01523458, 1, "R7");
    for (int i = 0; i < 8; i++) access(32'h01523458 + i, 0, "R8");
    access(32'h01523450, 0, "R9");
    access(32'h01523460, 0, "R9");
    access(32'h00123458, 0, "R12");
    access(32'hFD523458, 0, "R12");
    // R11: valid low with matching address, then hit/miss alternation
    @(negedge clk);
    acc_valid = 0; acc_addr = 32'h01523458; acc_is_write = 0;
    sb.push_back('{0, "R11"});
    access(32'h0152345C, 0, "R11");
    access(32'h01523460, 0, "R11");
    access(32'h01523459, 0, "R11");
    idle("R11");
    idle("R11");

    // write enable only
    wr_reg(5'd18, 32'h0012345A);
    rd_chk(5'd18, 32'h0012345A, "R2");
    access(32'h01523458, 1, "R6");
    access(32'h0152345F, 1, "R6");
    access(32'h01523458, 0, "R7");
    access(32'h01523468, 1, "R9");

    // both enables clear
    wr_reg(5'd18, 32'h00123458);
    for (int i = 0; i < 8; i++) begin
      access(32'h01523458 + i, 0, "R10");
      access(32'h01523458 + i, 1, "R10");
    end

    // high word zero: low 4 MB, top doubleword, both enables
    wr_reg(5'd19, 32'h0);
    wr_reg(5'd18, 32'h003FFFFB);
    rd_chk(5'd18, 32'h003FFFFB, "R2");
    access(32'h003FFFFF, 0, "R5");
    access(32'h003FFFF8, 1, "R6");
    access(32'h00400000, 0, "R9");
    access(32'h00BFFFF8, 1, "R12");
    idle("R11");
    idle("R11");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 pending items actual %0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule